// File: doc/BRIEF.md
# Serial Nine Detector (Binary and Excess-3)

This block watches a one-bit serial stream and flags each arrival of the decimal value nine in either of two 4-bit codes. One code is plain binary `1001`. The other is excess-3 `1100`. In both, the first bit received is the leftmost bit. It is a Moore machine: the flag comes only from the current state. The flag goes high for one cycle, in the clock cycle after the last bit of a pattern is sampled.

Detection does not overlap. When a pattern completes, the machine restarts from scratch. The bits of that pattern are never reused for a later match.

When an incoming bit breaks a partial match, the machine keeps the longest tail of the received bits that still begins one of the two codes. Seven states are kept in a 3-bit register with a fixed code assignment:

| State | Meaning | Code |
|---|---|---|
| idle | start | `000` |
| seen `1` | | `010` |
| seen `10` | | `101` |
| seen `100` | | `100` |
| seen `11` | | `111` |
| seen `110` | | `011` |
| hit | detection | `001` |

The remaining code `110` always leads back to idle.

Top module: `nine_seq_detector`

## Requirements
- R1: A synchronous reset (rst high at a rising clock edge) puts the machine in its start state, and z_out is low in the following cycle. Any partial match received before the reset is discarded.
- R2: After the bits 1,0,0,1 arrive on x_in on consecutive clock edges with no detection in between, z_out is high in the cycle after the edge that samples the final 1.
- R3: After the bits 1,1,0,0 arrive on x_in on consecutive clock edges with no detection in between, z_out is high in the cycle after the edge that samples the final 0.
- R4: Each detection raises z_out for exactly one clock cycle; z_out is never high on two consecutive cycles.
- R5: Detection is non-overlapping: after a detection, only bits sampled after the completing bit can form the next match. For example, 1001001 and 1100100 each give exactly one detection.
- R6: A bit that breaks a partial match leaves the machine at the longest tail of the bits received since the last detection or reset that is still a prefix of 1001 or 1100. For example, 101001 detects on its sixth bit and 11100 detects on its fifth bit.
- R7: For the stream 1001100011001, z_out is high exactly after the 4th and the 12th bits, and at no other position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| x_in | input | 1 | Serial data bit, sampled on each rising edge |
| z_out | output | 1 | Detection flag, high for one cycle per detected nine |

## Verification
On every cycle, the embedded assertions check several things:
- the one-cycle width of the flag;
- that the flag follows the final bit from each of the two almost-complete states;
- the restart behaviour after a hit;
- the fall-back from a broken `10`;
- that the state register never holds the spare code.

Whether a whole stream gives the correct detections can only be shown by the bench's scenarios. Those scenarios cover:
- non-overlap on back-to-back patterns;
- the longest-tail recovery on longer mismatch runs;
- the discard of a partial match across a mid-stream reset;
- the long random stream compared against an independent history-based model.

// File: rtl/nine_det_pkg.sv
package nine_det_pkg;

    localparam int STATE_W = 3;

    // Fixed state code assignment (adjacency-driven), written MSB..LSB
    typedef enum logic [STATE_W-1:0] {
        ST_IDLE    = 3'b000,  // nothing useful received
        ST_P1      = 3'b010,  // tail "1"
        ST_P10     = 3'b101,  // tail "10"
        ST_P100    = 3'b100,  // tail "100"  (binary nine almost done)
        ST_P11     = 3'b111,  // tail "11"
        ST_P110    = 3'b011,  // tail "110"  (excess-3 nine almost done)
        ST_HIT     = 3'b001   // detection, behaves like idle for the next bit
    } det_state_e;

    localparam logic [STATE_W-1:0] SPARE_CODE = 3'b110;

    // Next state: longest tail that still starts one of the two patterns.
    function automatic det_state_e step_state(input det_state_e cur, input logic bit_in);
        det_state_e nxt;
        case (cur)
            ST_IDLE, ST_HIT: nxt = bit_in ? ST_P1   : ST_IDLE;
            ST_P1:           nxt = bit_in ? ST_P11  : ST_P10;
            ST_P10:          nxt = bit_in ? ST_P1   : ST_P100;
            ST_P100:         nxt = bit_in ? ST_HIT  : ST_IDLE;
            ST_P11:          nxt = bit_in ? ST_P11  : ST_P110;
            ST_P110:         nxt = bit_in ? ST_P1   : ST_HIT;
            default:         nxt = ST_IDLE;  // spare code recovers
        endcase
        return nxt;
    endfunction

    function automatic logic state_flags_hit(input det_state_e cur);
        return (cur == ST_HIT);
    endfunction

endpackage

// File: rtl/nine_det_next.sv
module nine_det_next
    import nine_det_pkg::*;
(
    input  det_state_e cur_state,
    input  logic       bit_in,
    output det_state_e nxt_state
);
    always_comb begin
        nxt_state = step_state(cur_state, bit_in);
    end
endmodule

// File: rtl/nine_det_state_reg.sv
module nine_det_state_reg
    import nine_det_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  det_state_e d_state,
    output det_state_e q_state
);
    always_ff @(posedge clk) begin
        if (rst) q_state <= ST_IDLE;
        else     q_state <= d_state;
    end
endmodule

// File: rtl/nine_det_out.sv
module nine_det_out
    import nine_det_pkg::*;
(
    input  det_state_e cur_state,
    output logic       hit
);
    always_comb begin
        hit = state_flags_hit(cur_state);
    end
endmodule

// File: rtl/nine_seq_detector.sv
module nine_seq_detector
    import nine_det_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic x_in,
    output logic z_out
);
    det_state_e cur_state;
    det_state_e nxt_state;

    nine_det_next u_next (
        .cur_state (cur_state),
        .bit_in    (x_in),
        .nxt_state (nxt_state)
    );

    nine_det_state_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .d_state (nxt_state),
        .q_state (cur_state)
    );

    nine_det_out u_out (
        .cur_state (cur_state),
        .hit       (z_out)
    );

    // ---------------- assertions ----------------
    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    always_ff @(posedge clk) begin
        if (rst_q) begin
            assert_reset_idle_R1: assert (cur_state == ST_IDLE && !z_out)
                else $error("R1: not idle after reset");
        end
    end

    assert_bin_detect_R2: assert property (@(posedge clk) disable iff (rst)
        (cur_state == ST_P100 && x_in) |=> z_out);

    assert_xs3_detect_R3: assert property (@(posedge clk) disable iff (rst)
        (cur_state == ST_P110 && !x_in) |=> z_out);

    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        z_out |=> !z_out);

    assert_restart_one_R5: assert property (@(posedge clk) disable iff (rst)
        (z_out && x_in) |=> (cur_state == ST_P1));

    assert_restart_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (z_out && !x_in) |=> (cur_state == ST_IDLE));

    assert_fallback_R6: assert property (@(posedge clk) disable iff (rst)
        (cur_state == ST_P10 && x_in) |=> (cur_state == ST_P1 && !z_out));

    assert_legal_code_R6: assert property (@(posedge clk) disable iff (rst)
        !rst_q |-> (cur_state != SPARE_CODE));

endmodule

// File: tb/nine_seq_detector_bench.sv
module nine_seq_detector_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic x_in = 1'b0;
    logic z_out;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // independent model: bits since last detection/reset
    logic [3:0] hist = 4'b0;
    int         cnt  = 0;

    always #4 clk = ~clk;

    nine_seq_detector u_nine_seq_detector (
        .clk   (clk),
        .rst   (rst),
        .x_in  (x_in),
        .z_out (z_out)
    );

    function automatic logic model_hit(input logic [3:0] h, input int n);
        return (n >= 4) && (h == 4'b1001 || h == 4'b1100);
    endfunction

    task automatic check(input logic act, input logic exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: z_out=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // called at a falling edge; returns at the next falling edge after checking
    task automatic send(input logic b, input string req);
        logic exp;
        x_in = b;
        hist = {hist[2:0], b};
        cnt++;
        exp = model_hit(hist, cnt);
        if (exp) cnt = 0;
        @(posedge clk);
        @(negedge clk);
        check(z_out, exp, req);
    endtask

    task automatic send_str(input logic [15:0] bits, input int n, input string req);
        for (int i = n - 1; i >= 0; i--) send(bits[i], req);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cnt = 0;
        hist = 4'b0;
        check(z_out, 1'b0, "R1");
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: expected=done actual=hung");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        do_reset();                                   // R1

        send_str(16'b1001, 4, "R2");                  // R2
        send(1'b0, "R4");                              // R4 pulse ends
        send_str(16'b1100, 4, "R3");                  // R3
        send(1'b1, "R4");                              // R4
        do_reset();

        send_str(16'b1001001, 7, "R5");               // R5 non-overlap
        do_reset();
        send_str(16'b1100100, 7, "R5");               // R5 non-overlap
        do_reset();

        send_str(16'b101001, 6, "R6");                // R6 fallback from "10"
        do_reset();
        send_str(16'b11100, 5, "R6");                 // R6 stay at "11"
        do_reset();
        send_str(16'b1101100, 7, "R6");               // R6 "1101" -> tail "1"
        do_reset();

        send_str(16'b1001100011001, 13, "R7");        // R7 reference stream
        do_reset();

        // R1: partial match dropped by a mid-stream reset
        send_str(16'b100, 3, "R1");
        do_reset();
        send(1'b1, "R1");
        send_str(16'b001, 3, "R2");

        // random stream checked against the history model
        for (int i = 0; i < 4000; i++) begin
            send(1'($urandom_range(0, 1)), "R6");
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule